// File: doc/BRIEF.md
# Quad-Pumped Bus-Inversion Codec

This block encodes and decodes data for a 64-bit active-low data bus that moves four data beats in every bus clock. The transmit half takes one 256-bit payload per bus clock through a valid/ready handshake and sends it as four 64-bit beats. The beats are modelled by an internal beat counter, and each one occupies one cycle of the block clock. In every beat, each 16-bit lane group is checked on its own. When more than half of its bits would be driven electrically low, the group is sent inverted and its inversion flag is driven active.

The receive half captures beats one group at a time. Each group has its own capture strobe, so the four groups may arrive skewed against each other. Each group's flag undoes any inversion, and the 256-bit payload is rebuilt. A one-cycle valid pulse follows the last group's final beat. Strobe generation, pad timing, parity and arbitration belong to the surrounding logic.

Top module: `qbi_link`

## Requirements
- R1: The bus is split into groups 0..3 covering bits 15:0, 31:16, 47:32 and 63:48. Flag bit g of `bus_inv_n` and `rx_inv_n` belongs to group g. Strobe bit g of `rx_strb_vld` also belongs to group g.
- R2: In each beat, a group is inverted exactly when its logical value has more than 8 ones. A group with exactly 8 ones is sent uninverted.
- R3: The bus is active-low. Electrical `bus_d_n` is the bitwise complement of the logical group value actually sent, which is the true value or its inverse. A flag is active when it is 0.
- R4: An accepted payload is sent as beats 0,1,2,3 in consecutive cycles, and beat k carries payload bits [64k+63:64k].
- R5: `tx_ready` is 1 when the transmitter is idle or in beat 3. A transfer with `tx_valid` and `tx_ready` both high puts beat 0 on the bus in the next cycle. With `tx_valid` held high, frames follow each other with no idle cycle.
- R6: While `bus_vld` is 0, `bus_d_n` and `bus_inv_n` are all ones.
- R7: No group ever drives more than 8 electrically low bits in a valid beat.
- R8: The receiver recovers each group as `~rx_d_n` when its flag is 1 and as `rx_d_n` when its flag is 0. After loopback, `rx_data` equals the transmitted payload.
- R9: Each group counts its own four captures on its own strobe. `rx_valid` is a one-cycle pulse in the cycle after the last group completes its fourth capture, and it stays 0 before that, whatever the skew between groups.
- R10: After reset, `tx_ready`=1, `bus_vld`=0 and `rx_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock (four cycles per bus clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Payload offered |
| tx_ready | output | 1 | Payload can be taken this cycle |
| tx_data | input | 256 | Payload, beat 0 in the low 64 bits |
| bus_d_n | output | 64 | Electrical data lanes, active-low |
| bus_inv_n | output | 4 | Per-group inversion flags, active-low |
| bus_vld | output | 1 | A beat is on the bus |
| rx_strb_vld | input | 4 | Per-group capture strobe |
| rx_d_n | input | 64 | Received electrical data lanes |
| rx_inv_n | input | 4 | Received per-group flags, active-low |
| rx_valid | output | 1 | Rebuilt payload valid, one cycle |
| rx_data | output | 256 | Rebuilt payload |

## Verification
The inversion threshold is hard to cover from the ports, because payload values must hit popcounts 8 and 9 in every group and every beat position. The bench reaches it by running every 16-bit value once. It packs sixteen values per frame, one per group slot, so 4096 back-to-back frames cover all 65536 patterns, and every beat is compared against an arithmetic model. Group skew cannot arise in loopback. A second phase therefore drives the receive pins directly and staggers each group's strobes by one cycle per group index.

// File: rtl/qbi_pkg.sv
// Shared sizing for the quad-pumped bus-inversion codec.
// Assumes the frame is always N_BEAT beats of N_GRP groups of GRP_W bits.
package qbi_pkg;
    localparam int QBI_GRP_W  = 16;
    localparam int QBI_N_GRP  = 4;
    localparam int QBI_N_BEAT = 4;
endpackage

// File: rtl/qbi_grp_enc.sv
// Per-group inversion encoder. It counts the logical ones of one group
// (each would be an electrical low) and inverts when the count exceeds half.
// Assumes: purely combinational; the caller applies idle forcing.
module qbi_grp_enc #(
    parameter int GRP_W = qbi_pkg::QBI_GRP_W
) (
    input  logic [GRP_W-1:0] val,
    output logic [GRP_W-1:0] pins_n,
    output logic             inv_n
);
    localparam int CW = $clog2(GRP_W + 1);

    logic [CW-1:0] ones;
    logic          inv;

    // Count the bits that would be driven low, then take the majority decision.
    always_comb begin
        ones = '0;
        for (int i = 0; i < GRP_W; i++) begin
            ones = ones + CW'(val[i]);
        end
        inv    = (ones > CW'(GRP_W / 2));
        pins_n = inv ? val : ~val;
        inv_n  = ~inv;
    end
endmodule

// File: rtl/qbi_tx.sv
// Transmit half: accepts a full frame per handshake and plays it out as
// N_BEAT beats, encoding every group of every beat on its own.
// Assumes: a new frame may be accepted during the final beat (no gap).
module qbi_tx #(
    parameter int GRP_W  = qbi_pkg::QBI_GRP_W,
    parameter int N_GRP  = qbi_pkg::QBI_N_GRP,
    parameter int N_BEAT = qbi_pkg::QBI_N_BEAT
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tx_valid,
    output logic                            tx_ready,
    input  logic [N_BEAT*N_GRP*GRP_W-1:0]   tx_data,
    output logic [N_GRP*GRP_W-1:0]          bus_d_n,
    output logic [N_GRP-1:0]                bus_inv_n,
    output logic                            bus_vld
);
    localparam int BUS_W   = N_GRP * GRP_W;
    localparam int FRAME_W = BUS_W * N_BEAT;
    localparam int BW      = (N_BEAT > 1) ? $clog2(N_BEAT) : 1;

    logic               busy;
    logic [BW-1:0]      beat;
    logic [FRAME_W-1:0] payload;
    logic [BUS_W-1:0]   beat_val;
    logic               last_beat;

    // Select the current beat slice and work out the handshake.
    always_comb begin
        last_beat = (beat == BW'(N_BEAT - 1));
        tx_ready  = !busy || last_beat;
        beat_val  = payload[int'(beat)*BUS_W +: BUS_W];
    end

    // Frame register and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            beat    <= '0;
            payload <= '0;
        end else if (tx_valid && tx_ready) begin
            payload <= tx_data;
            beat    <= '0;
            busy    <= 1'b1;
        end else if (busy) begin
            beat <= beat + BW'(1);
            if (last_beat) begin
                busy <= 1'b0;
            end
        end
    end

    assign bus_vld = busy;

    for (genvar g = 0; g < N_GRP; g++) begin : g_enc
        logic [GRP_W-1:0] pins_n;
        logic             inv_n;

        qbi_grp_enc #(.GRP_W(GRP_W)) i_enc (
            .val    (beat_val[g*GRP_W +: GRP_W]),
            .pins_n (pins_n),
            .inv_n  (inv_n)
        );

        // Idle lanes float high (deasserted); active beats carry the encoding.
        assign bus_d_n[g*GRP_W +: GRP_W] = busy ? pins_n : '1;
        assign bus_inv_n[g]              = busy ? inv_n : 1'b1;
    end
endmodule

// File: rtl/qbi_rx.sv
// Receive half: each group captures on its own strobe into its own beat
// slots, undoing inversion per flag; a pulse marks the frame complete.
// Assumes: group skew is less than one frame, so no group starts the next
// frame before all groups finish the current one.
module qbi_rx #(
    parameter int GRP_W  = qbi_pkg::QBI_GRP_W,
    parameter int N_GRP  = qbi_pkg::QBI_N_GRP,
    parameter int N_BEAT = qbi_pkg::QBI_N_BEAT
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_GRP-1:0]                rx_strb_vld,
    input  logic [N_GRP*GRP_W-1:0]          rx_d_n,
    input  logic [N_GRP-1:0]                rx_inv_n,
    output logic                            rx_valid,
    output logic [N_BEAT*N_GRP*GRP_W-1:0]   rx_data
);
    localparam int BUS_W = N_GRP * GRP_W;
    localparam int BW    = (N_BEAT > 1) ? $clog2(N_BEAT) : 1;

    logic [N_GRP-1:0] fin;
    logic [N_GRP-1:0] done;
    logic             all_done;

    for (genvar g = 0; g < N_GRP; g++) begin : g_lane
        logic [BW-1:0]                 cnt;
        logic [N_BEAT-1:0][GRP_W-1:0]  slots;
        logic [GRP_W-1:0]              dec;

        // Restore the logical value: flag inactive means plain active-low.
        assign dec    = rx_inv_n[g] ? ~rx_d_n[g*GRP_W +: GRP_W] : rx_d_n[g*GRP_W +: GRP_W];
        assign fin[g] = rx_strb_vld[g] && (cnt == BW'(N_BEAT - 1));

        // Per-group beat counter and slot store.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt   <= '0;
                slots <= '0;
            end else if (rx_strb_vld[g]) begin
                slots[cnt] <= dec;
                cnt        <= fin[g] ? '0 : cnt + BW'(1);
            end
        end

        for (genvar b = 0; b < N_BEAT; b++) begin : g_out
            assign rx_data[b*BUS_W + g*GRP_W +: GRP_W] = slots[b];
        end
    end

    assign all_done = &(done | fin);

    // Frame completion tracking across groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= '0;
            rx_valid <= 1'b0;
        end else if (all_done) begin
            done     <= '0;
            rx_valid <= 1'b1;
        end else begin
            done     <= done | fin;
            rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/qbi_link.sv
// Top of the quad-pumped bus-inversion codec: transmit encoder and receive
// decoder side by side, sharing one beat clock.
// Assumes: clk runs at N_BEAT times the bus clock; reset is synchronous.
module qbi_link #(
    parameter int GRP_W  = qbi_pkg::QBI_GRP_W,
    parameter int N_GRP  = qbi_pkg::QBI_N_GRP,
    parameter int N_BEAT = qbi_pkg::QBI_N_BEAT
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tx_valid,
    output logic                            tx_ready,
    input  logic [N_BEAT*N_GRP*GRP_W-1:0]   tx_data,
    output logic [N_GRP*GRP_W-1:0]          bus_d_n,
    output logic [N_GRP-1:0]                bus_inv_n,
    output logic                            bus_vld,
    input  logic [N_GRP-1:0]                rx_strb_vld,
    input  logic [N_GRP*GRP_W-1:0]          rx_d_n,
    input  logic [N_GRP-1:0]                rx_inv_n,
    output logic                            rx_valid,
    output logic [N_BEAT*N_GRP*GRP_W-1:0]   rx_data
);
    qbi_tx #(.GRP_W(GRP_W), .N_GRP(N_GRP), .N_BEAT(N_BEAT)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .bus_d_n   (bus_d_n),
        .bus_inv_n (bus_inv_n),
        .bus_vld   (bus_vld)
    );

    qbi_rx #(.GRP_W(GRP_W), .N_GRP(N_GRP), .N_BEAT(N_BEAT)) i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_strb_vld (rx_strb_vld),
        .rx_d_n      (rx_d_n),
        .rx_inv_n    (rx_inv_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data)
    );
endmodule

// File: rtl/qbi_link_chk.sv
// Port-level property checker for qbi_link, attached by bind.
// Assumes: only the top-level ports are observed.
module qbi_link_chk #(
    parameter int GRP_W  = qbi_pkg::QBI_GRP_W,
    parameter int N_GRP  = qbi_pkg::QBI_N_GRP,
    parameter int N_BEAT = qbi_pkg::QBI_N_BEAT
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tx_valid,
    input logic                   tx_ready,
    input logic [N_GRP*GRP_W-1:0] bus_d_n,
    input logic [N_GRP-1:0]       bus_inv_n,
    input logic                   bus_vld,
    input logic                   rx_valid
);
    // R6: idle lanes and flags deasserted.
    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_vld |-> (&bus_d_n) && (&bus_inv_n));

    // R5: an accepted frame starts on the next cycle.
    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> bus_vld);

    // R5: a frame in progress is not cut short.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !tx_ready) |=> bus_vld);

    // R9: completion is a single-cycle pulse.
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    for (genvar g = 0; g < N_GRP; g++) begin : g_chk
        // R7: never more than half the group low.
        p_low_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            bus_vld |-> ($countones(~bus_d_n[g*GRP_W +: GRP_W]) <= GRP_W / 2));

        // R2: an inverted group must end up strictly below half low.
        p_inv_lowcnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_vld && !bus_inv_n[g]) |-> ($countones(~bus_d_n[g*GRP_W +: GRP_W]) < GRP_W / 2));
    end
endmodule

bind qbi_link qbi_link_chk #(.GRP_W(GRP_W), .N_GRP(N_GRP), .N_BEAT(N_BEAT)) i_qbi_link_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .bus_d_n   (bus_d_n),
    .bus_inv_n (bus_inv_n),
    .bus_vld   (bus_vld),
    .rx_valid  (rx_valid)
);

// File: tb/test_qbi_link.sv
// Exhaustive sweep of every 16-bit group value through the codec in
// loopback, then a skewed-strobe receive test driven directly.
module test_qbi_link;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_valid = 1'b0;
    logic         tx_ready;
    logic [255:0] tx_data = '0;
    logic [63:0]  bus_d_n;
    logic [3:0]   bus_inv_n;
    logic         bus_vld;
    logic [3:0]   rx_strb_vld;
    logic [63:0]  rx_d_n;
    logic [3:0]   rx_inv_n;
    logic         rx_valid;
    logic [255:0] rx_data;

    logic         lb = 1'b1;
    logic [3:0]   drv_vld = '0;
    logic [63:0]  drv_d_n = '1;
    logic [3:0]   drv_inv_n = '1;

    int checks = 0;
    int fails = 0;

    logic [255:0] txq[$];
    logic [255:0] rxq[$];
    logic [255:0] cur;
    int           mb = 0;
    int           run_len = 0;
    int           max_run = 0;

    always #2 clk = ~clk;

    assign rx_strb_vld = lb ? {4{bus_vld}} : drv_vld;
    assign rx_d_n      = lb ? bus_d_n : drv_d_n;
    assign rx_inv_n    = lb ? bus_inv_n : drv_inv_n;

    qbi_link i_qbi_link (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .bus_d_n(bus_d_n), .bus_inv_n(bus_inv_n),
        .bus_vld(bus_vld), .rx_strb_vld(rx_strb_vld), .rx_d_n(rx_d_n),
        .rx_inv_n(rx_inv_n), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    function automatic int popc(input logic [15:0] v);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(v[i]);
        return n;
    endfunction

    // Expected electrical pins: active-low of the value actually sent.
    function automatic logic [15:0] exp_pins(input logic [15:0] v);
        return (popc(v) > 8) ? v : ~v;
    endfunction

    function automatic logic exp_flag_n(input logic [15:0] v);
        return (popc(v) > 8) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Transmit-side monitor: compares every beat with the model (R1-related
    // group slicing, R2 threshold, R3 polarity, R4 beat order).
    always @(negedge clk) begin
        if (rst_n && lb) begin
            if (bus_vld) begin
                run_len++;
                if (run_len > max_run) max_run = run_len;
                if (mb == 0) begin
                    if (txq.size() > 0) cur = txq.pop_front();
                end
                for (int g = 0; g < 4; g++) begin
                    logic [15:0] v;
                    v = cur[mb*64 + g*16 +: 16];
                    chk("R2 R3 R4 data", 256'(bus_d_n[g*16 +: 16]), 256'(exp_pins(v)));
                    chk("R1 R2 flag", 256'(bus_inv_n[g]), 256'(exp_flag_n(v)));
                end
                mb = (mb + 1) % 4;
            end else begin
                run_len = 0;
            end
            if (rx_valid) begin
                if (rxq.size() > 0) chk("R8 loopback", rx_data, rxq.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [255:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R6 idle levels
        chk("R10 tx_ready", 256'(tx_ready), 256'(1));
        chk("R10 bus_vld", 256'(bus_vld), 256'(0));
        chk("R10 rx_valid", 256'(rx_valid), 256'(0));
        chk("R6 idle data", 256'(bus_d_n), 256'({64{1'b1}}));
        chk("R6 idle flags", 256'(bus_inv_n), 256'(4'hF));

        // Exhaustive sweep: frame f slot s holds value f*16+s, back to back.
        for (int f = 0; f < 4096; f++) begin
            for (int s = 0; s < 16; s++) begin
                p[(s/4)*64 + (s%4)*16 +: 16] = 16'(f*16 + s);
            end
            tx_data  = p;
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            txq.push_back(p);
            rxq.push_back(p);
            @(negedge clk);
        end
        tx_valid = 1'b0;
        repeat (10) @(negedge clk);
        // R5 back-to-back: the whole sweep is one unbroken run of beats
        chk("R5 no gap", 256'(max_run), 256'(4096*4));
        chk("R6 idle after", 256'(bus_d_n), 256'({64{1'b1}}));
        chk("R8 queue drained", 256'(rxq.size()), 256'(0));

        // Skew test: group g strobes beats during cycles g..g+3.
        lb = 1'b0;
        for (int s = 0; s < 16; s++) p[s*16 +: 16] = 16'(16'h0FF0 ^ (s * 16'h1357));
        p[15:0] = 16'h00FF;   // exactly 8 ones: R2 boundary, not inverted
        p[31:16] = 16'h01FF;  // 9 ones: inverted
        for (int t = 0; t < 7; t++) begin
            if (t > 0) chk("R9 no early valid", 256'(rx_valid), 256'(0));
            for (int g = 0; g < 4; g++) begin
                int b;
                b = t - g;
                if (b >= 0 && b < 4) begin
                    drv_vld[g] = 1'b1;
                    drv_d_n[g*16 +: 16] = exp_pins(p[b*64 + g*16 +: 16]);
                    drv_inv_n[g] = exp_flag_n(p[b*64 + g*16 +: 16]);
                end else begin
                    drv_vld[g] = 1'b0;
                    drv_d_n[g*16 +: 16] = '1;
                    drv_inv_n[g] = 1'b1;
                end
            end
            @(negedge clk);
        end
        drv_vld = '0;
        chk("R9 valid pulse", 256'(rx_valid), 256'(1));
        chk("R9 R8 skew data", rx_data, p);
        @(negedge clk);
        chk("R9 pulse ends", 256'(rx_valid), 256'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule